// File: doc/BRIEF.md
# Quad-Rate Burst SRAM Port Model

This block is a small register-built memory behind an interface with two data directions that run at once. Write data enters on its own input bus and read data leaves on its own output bus, so a read burst and a write burst can overlap with no bus turnaround. Both directions take their addresses from one shared address bus. Each address names a location of four words. Those four words move as one burst, one word per half cycle of the main clock, so a burst lasts two main-clock cycles.

The model has one clock, `clk`. Each rising edge of `clk` stands for one rising edge of the main clock or of its complement. Count the edges after reset from zero: edge e falls in slot e mod 4. The main-clock edges that take addresses are slot 0 (read address) and slot 2 (write address). A free-running two-bit phase counter fixes both the slot and the word index inside a burst. No burst word index is ever taken from the address bus. A write is held in a pending buffer and reaches the array only when the next write burst starts. A read that hits the pending location takes its data from that buffer, so it always sees the newest data. Next to the read data, the output gives a valid flag and an echo clock that lines up with the read data.

Top module: `qrb_sram`

## Requirements
- R1: A read issued in slot 0 and a write issued in slot 2 of the same four-edge frame both complete. The read returns the data that was stored before that write.
- R2: The read select and the address are sampled for a read only at slot-0 edges. The write select and the address are sampled for a write only at slot-2 edges. Select and address values at any other edge have no effect on the outputs or on the memory.
- R3: The read burst returns words 0, 1, 2 and 3 of the location, in that order, one word per edge.
- R4: For a write address taken at edge m, write-data word k is sampled at edge m+k, for k from 0 to 3.
- R5: For a read address taken at edge n, word k is on `rdata` after edge n+3+k. `rvalid` is high after exactly those four edges.
- R6: If `rd_sel_n` is high at a slot-0 edge, no burst is returned for that slot. If `wr_sel_n` is high at a slot-2 edge, the memory is left unchanged.
- R7: A read issued in the frame after a write to the same location returns the newly written words. These words are forwarded from the pending write buffer.
- R8: After edge e, `echo_clk` equals bit 0 of e. It is therefore high while words 0 and 2 of a burst are presented, and it toggles on every edge.
- R9: `rdata` is zero whenever `rvalid` is low.
- R10: While `rst` is high, `rvalid` is 0, `rdata` is 0 and `echo_clk` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Edge clock; each rising edge is one half cycle of the main clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_sel_n | input | 1 | Active-low read select, used at slot-0 edges |
| wr_sel_n | input | 1 | Active-low write select, used at slot-2 edges |
| addr | input | AW | Shared location address for both directions |
| wdata | input | DW | Write data, one word per edge during a write burst |
| rdata | output | DW | Read data, one word per edge during a read burst |
| rvalid | output | 1 | High while `rdata` carries a burst word |
| echo_clk | output | 1 | Registered clock aligned to the read data |

## Verification
The assertions assume that the inputs change only between edges and that the first edge after reset is slot 0. They also assume that reads and writes are issued only in their own slots. The bench meets these assumptions by driving on the falling edge and by counting edges from the release of reset. It builds every access from a four-edge frame plan. Selects and addresses outside the command slots are driven at random, and in marked noisy frames they are driven active on purpose. This puts them inside the stated assumptions while still testing that they are ignored. Every location is written before it is first read, so the reset-free array never returns undefined data to a check.

// File: rtl/qrb_pkg.sv
package qrb_pkg;

    localparam int BURST_LEN = 4;

    // Meaning of each edge slot inside a four-edge frame
    typedef enum logic [1:0] {
        PH_RD_SLOT  = 2'd0,   // read address sampled at the ports
        PH_RD_LATCH = 2'd1,   // captured read request accepted by the core
        PH_WR_SLOT  = 2'd2,   // write address and word 0 sampled at the ports
        PH_WR_LATCH = 2'd3    // captured write request accepted by the core
    } phase_e;

    // Burst word handled by the core at a given phase. Writes store word
    // (phase+1) and reads present word (phase+1); the mapping wraps.
    function automatic logic [1:0] burst_word(input logic [1:0] ph);
        return ph + 2'd1;
    endfunction

endpackage

// File: rtl/qrb_in_stage.sv
module qrb_in_stage #(
    parameter int AW = 4,
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_sel_n,
    input  logic          wr_sel_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          cap_rd_n,
    output logic          cap_wr_n,
    output logic [AW-1:0] cap_addr,
    output logic [DW-1:0] cap_wdata
);
    // Every synchronous input is registered before the core uses it
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_rd_n <= 1'b1;
            cap_wr_n <= 1'b1;
        end else begin
            cap_rd_n <= rd_sel_n;
            cap_wr_n <= wr_sel_n;
        end
        cap_addr  <= addr;
        cap_wdata <= wdata;
    end
endmodule

// File: rtl/qrb_write_buf.sv
module qrb_write_buf
    import qrb_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 18
) (
    input  logic                          clk,
    input  logic                          rst,
    input  phase_e                        phase,
    input  logic                          cap_wr_n,
    input  logic [AW-1:0]                 cap_addr,
    input  logic [DW-1:0]                 cap_wdata,
    output logic [AW-1:0]                 pend_addr,
    output logic [BURST_LEN-1:0][DW-1:0]  pend_data,
    output logic [BURST_LEN-1:0]          pend_mask,
    output logic                          commit_en
);
    logic       filling;
    logic       start;
    logic [1:0] widx;

    assign start = (phase == PH_WR_LATCH) && !cap_wr_n;
    assign widx  = burst_word(phase);
    // The previous burst goes into the array when a new one begins
    assign commit_en = start && (&pend_mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_mask <= '0;
            filling   <= 1'b0;
        end else if (start) begin
            pend_mask <= BURST_LEN'(1);
            filling   <= 1'b1;
        end else if (filling) begin
            pend_mask[widx] <= 1'b1;
            if (phase == PH_WR_SLOT)
                filling <= 1'b0;
        end
    end

    // Buffer contents carry no reset
    always_ff @(posedge clk) begin
        if (!rst && start) begin
            pend_addr    <= cap_addr;
            pend_data[0] <= cap_wdata;
        end else if (!rst && filling) begin
            pend_data[widx] <= cap_wdata;
        end
    end
endmodule

// File: rtl/qrb_store.sv
module qrb_store #(
    parameter int AW    = 4,
    parameter int DW    = 18,
    parameter int DEPTH = 16,
    parameter int NW    = 4
) (
    input  logic                   clk,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [NW-1:0][DW-1:0]  wr_data,
    input  logic [AW-1:0]          rd_addr,
    input  logic [$clog2(NW)-1:0]  rd_word,
    output logic [DW-1:0]          rd_data
);
    logic [NW-1:0][DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr][rd_word];
endmodule

// File: rtl/qrb_read_path.sv
module qrb_read_path
    import qrb_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 18
) (
    input  logic                          clk,
    input  logic                          rst,
    input  phase_e                        phase,
    input  logic                          cap_rd_n,
    input  logic [AW-1:0]                 cap_addr,
    input  logic [AW-1:0]                 pend_addr,
    input  logic [BURST_LEN-1:0][DW-1:0]  pend_data,
    input  logic [BURST_LEN-1:0]          pend_mask,
    input  logic [DW-1:0]                 arr_word,
    output logic [AW-1:0]                 arr_addr,
    output logic [1:0]                    arr_sel,
    output logic [DW-1:0]                 rdata,
    output logic                          rvalid,
    output logic                          echo_clk
);
    logic          req_v, out_v;
    logic [AW-1:0] req_a, out_a;
    logic          hit;
    logic [DW-1:0] word;

    assign arr_addr = out_a;
    assign arr_sel  = burst_word(phase);
    assign hit      = (out_a == pend_addr) && pend_mask[arr_sel];
    assign word     = hit ? pend_data[arr_sel] : arr_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_v    <= 1'b0;
            out_v    <= 1'b0;
            rvalid   <= 1'b0;
            rdata    <= '0;
            echo_clk <= 1'b1;
        end else begin
            if (phase == PH_RD_LATCH) begin
                req_v <= !cap_rd_n;
                req_a <= cap_addr;
            end
            if (phase == PH_WR_SLOT) begin
                out_v <= req_v;
                out_a <= req_a;
            end
            rvalid   <= out_v;
            rdata    <= out_v ? word : '0;
            echo_clk <= phase[0];
        end
    end
endmodule

// File: rtl/qrb_sram.sv
module qrb_sram
    import qrb_pkg::*;
#(
    parameter int DW    = 18,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_sel_n,
    input  logic          wr_sel_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          rvalid,
    output logic          echo_clk
);
    phase_e                        phase;
    logic                          cap_rd_n, cap_wr_n;
    logic [AW-1:0]                 cap_addr;
    logic [DW-1:0]                 cap_wdata;
    logic [AW-1:0]                 pend_addr;
    logic [BURST_LEN-1:0][DW-1:0]  pend_data;
    logic [BURST_LEN-1:0]          pend_mask;
    logic                          commit_en;
    logic [AW-1:0]                 arr_addr;
    logic [1:0]                    arr_sel;
    logic [DW-1:0]                 arr_word;

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_RD_SLOT;
        else     phase <= phase_e'(phase + 2'd1);
    end

    qrb_in_stage #(.AW(AW), .DW(DW)) u_in (
        .clk(clk), .rst(rst), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
        .addr(addr), .wdata(wdata), .cap_rd_n(cap_rd_n), .cap_wr_n(cap_wr_n),
        .cap_addr(cap_addr), .cap_wdata(cap_wdata)
    );

    qrb_write_buf #(.AW(AW), .DW(DW)) u_wbuf (
        .clk(clk), .rst(rst), .phase(phase), .cap_wr_n(cap_wr_n),
        .cap_addr(cap_addr), .cap_wdata(cap_wdata), .pend_addr(pend_addr),
        .pend_data(pend_data), .pend_mask(pend_mask), .commit_en(commit_en)
    );

    qrb_store #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .NW(BURST_LEN)) u_store (
        .clk(clk), .wr_en(commit_en), .wr_addr(pend_addr), .wr_data(pend_data),
        .rd_addr(arr_addr), .rd_word(arr_sel), .rd_data(arr_word)
    );

    qrb_read_path #(.AW(AW), .DW(DW)) u_rd (
        .clk(clk), .rst(rst), .phase(phase), .cap_rd_n(cap_rd_n),
        .cap_addr(cap_addr), .pend_addr(pend_addr), .pend_data(pend_data),
        .pend_mask(pend_mask), .arr_word(arr_word), .arr_addr(arr_addr),
        .arr_sel(arr_sel), .rdata(rdata), .rvalid(rvalid), .echo_clk(echo_clk)
    );
endmodule

// File: rtl/qrb_sram_chk.sv
module qrb_sram_chk #(
    parameter int DW = 18
) (
    input logic          clk,
    input logic          rst,
    input logic          rd_sel_n,
    input logic [1:0]    phase,
    input logic [DW-1:0] rdata,
    input logic          rvalid,
    input logic          echo_clk
);
    // R8: echo clock toggles on every edge out of reset
    a_r8_echo_toggle: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (echo_clk != $past(echo_clk)));

    // R8: a burst starts while the echo clock is high
    a_r8_first_word_echo: assert property (@(posedge clk) disable iff (rst)
        $rose(rvalid) |-> echo_clk);

    // R5: selected read slot yields a valid word three edges later
    a_r5_read_latency: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd0 && !rd_sel_n) |-> ##4 rvalid);

    // R5: a burst lasts at least four edges
    a_r5_burst_len: assert property (@(posedge clk) disable iff (rst)
        $rose(rvalid) |=> rvalid ##1 rvalid ##1 rvalid);

    // R6: deselected read slot yields no word
    a_r6_no_valid_deselect: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd0 && rd_sel_n) |-> ##4 !rvalid);

    // R9: data bus idles at zero
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !rvalid |-> (rdata == '0));
endmodule

bind qrb_sram qrb_sram_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst(rst), .rd_sel_n(rd_sel_n), .phase(phase),
    .rdata(rdata), .rvalid(rvalid), .echo_clk(echo_clk)
);

// File: tb/sim_qrb_sram.sv
`timescale 1ns/1ps
module sim_qrb_sram;
    localparam int DW = 18;
    localparam int DEPTH = 16;
    localparam int AW = 4;
    localparam int NF = 240;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rd_sel_n = 1'b1, wr_sel_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic rvalid, echo_clk;

    always #2 clk = ~clk;

    qrb_sram #(.DW(DW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
        .echo_clk(echo_clk)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    bit            rd_en [NF];
    bit            wr_en [NF];
    bit            noisy [NF];
    logic [AW-1:0] raddr [NF];
    logic [AW-1:0] waddr [NF];
    logic [DW-1:0] wd    [NF][4];
    logic [DW-1:0] refm  [DEPTH][4];
    bit            ev [8];
    logic [DW-1:0] ed [8];
    string         etag [8];

    task automatic check(input string tag, input int e, input logic [DW-1:0] got,
                         input logic [DW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s edge %0d: got %h expected %h", tag, e, got, exp);
        end
    endtask

    function automatic string read_tag(input int f);
        if ((f > 0 && wr_en[f-1] && waddr[f-1] == raddr[f]) ||
            (wr_en[f] && waddr[f] == raddr[f])) return "R7";
        if (wr_en[f]) return "R1";
        return "R3";
    endfunction

    initial begin
        int seed;
        seed = $urandom(32'h5eed);
        for (int f = 0; f < NF; f++) begin
            rd_en[f] = 0; wr_en[f] = 0; noisy[f] = 0;
            raddr[f] = '0; waddr[f] = '0;
            for (int k = 0; k < 4; k++) wd[f][k] = DW'($urandom);
        end
        // fill every location first (reset-free array)
        for (int f = 0; f < DEPTH; f++) begin wr_en[f] = 1; waddr[f] = AW'(f); end
        rd_en[16] = 1; raddr[16] = 0;
        wr_en[17] = 1; waddr[17] = 5;                        // R7 setup
        rd_en[18] = 1; raddr[18] = 5;                        // R7 forward
        wr_en[19] = 1; waddr[19] = 5; rd_en[19] = 1; raddr[19] = 5; // R1 same frame
        rd_en[20] = 1; raddr[20] = 5; wr_en[20] = 1; waddr[20] = 9;
        rd_en[21] = 1; raddr[21] = 15; wr_en[21] = 1; waddr[21] = 0;
        noisy[22] = 1;                                       // R2 off-slot noise
        rd_en[23] = 1; raddr[23] = 0;
        noisy[24] = 1;                                       // R6 deselected write
        rd_en[25] = 1; raddr[25] = 9;
        rd_en[26] = 1; raddr[26] = 0;
        for (int f = 27; f < NF - 2; f++) begin
            rd_en[f] = ($urandom % 4) != 0;
            wr_en[f] = ($urandom % 4) != 0;
            noisy[f] = ($urandom % 8) == 0;
            raddr[f] = ($urandom % 2) ? AW'($urandom % 3) : AW'($urandom);
            waddr[f] = ($urandom % 2) ? AW'($urandom % 3) : AW'($urandom);
        end
        for (int s = 0; s < 8; s++) begin ev[s] = 0; ed[s] = '0; etag[s] = ""; end

        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 rvalid", -1, DW'(rvalid), '0);
        check("R10 rdata", -1, rdata, '0);
        check("R10 echo", -1, DW'(echo_clk), DW'(1));
        rst = 1'b0;

        for (int e = 0; e < 4 * NF; e++) begin
            int f, p, src;
            f = e / 4; p = e % 4;
            rd_sel_n = noisy[f] ? 1'b0 : 1'($urandom);
            wr_sel_n = noisy[f] ? 1'b0 : 1'($urandom);
            addr  = AW'($urandom);
            wdata = DW'($urandom);
            case (p)
                0: begin
                    rd_sel_n = !rd_en[f];
                    addr = raddr[f];
                    if (f > 0 && wr_en[f-1]) wdata = wd[f-1][2];
                    if (rd_en[f])
                        for (int k = 0; k < 4; k++) begin
                            ev[(e + 3 + k) % 8] = 1;
                            ed[(e + 3 + k) % 8] = refm[raddr[f]][k];
                            etag[(e + 3 + k) % 8] = read_tag(f);
                        end
                end
                1: if (f > 0 && wr_en[f-1]) wdata = wd[f-1][3];
                2: begin
                    wr_sel_n = !wr_en[f];   // R4 word 0 with the address
                    addr = waddr[f];
                    wdata = wd[f][0];
                    if (wr_en[f])
                        for (int k = 0; k < 4; k++) refm[waddr[f]][k] = wd[f][k];
                end
                default: wdata = wd[f][1];
            endcase
            @(posedge clk);
            @(negedge clk);
            check("R8 echo", e, DW'(echo_clk), DW'(e & 1));
            src = (e >= 3) ? (e - 3) / 4 : 0;
            if (ev[e % 8]) begin
                check("R5 rvalid", e, DW'(rvalid), DW'(1));
                check(etag[e % 8], e, rdata, ed[e % 8]);   // R3/R4 word order
            end else begin
                check(noisy[src] ? "R2 rvalid" : "R6 rvalid", e, DW'(rvalid), '0);
                check("R9 rdata", e, rdata, '0);
            end
            ev[e % 8] = 0;
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule